// File: doc/BRIEF.md
# Program Counter and Branch Steering Unit

This block owns the instruction address of a small 16-bit word-addressed core. Each cycle it takes the fields decoded from the current instruction (opcode, a 6-bit immediate, a 12-bit jump field) together with two operand register values. From these it picks the address of the next instruction. With no redirect the address advances by one.

Redirect targets are not formed by adding an offset. The two conditional branches keep the upper ten bits of the current address and put the immediate in the low six bits. The two absolute jumps keep the upper four bits and put the 12-bit field below them. The register jump loads the operand value whole. Every splice takes its upper bits from the current address, never from the incremented one.

The block also outputs the incremented address for the link write, a flag for the link-jump opcode, and a flag that is high whenever the sequential address is overridden.

Top module: `pc_steer`

## Requirements
- R1: When `rst_i` is high at a rising clock edge, `pc_o` becomes 0 after that edge, whatever the other inputs are.
- R2: For opcodes 0000 through 1010, the next `pc_o` is the current `pc_o` plus one, and 16'hFFFF wraps to 16'h0000.
- R3: `pc_inc_o` always equals `pc_o` + 1 modulo 2^16.
- R4: Opcode 1011 with `rs_val_i == rd_val_i` sets the next address to {current pc[15:6], imm_i}. With unequal operands it falls back to the R2 advance.
- R5: Opcode 1100 with `rs_val_i == 0` sets the next address to {current pc[15:6], imm_i}. With any other operand value it falls back to the R2 advance.
- R6: Opcode 1101 sets the next address to `rs_val_i`.
- R7: Opcode 1110 sets the next address to {current pc[15:12], jaddr_i}. `link_o` is high only for this opcode, and `pc_inc_o` carries the return address during it.
- R8: Opcode 1111 sets the next address to {current pc[15:12], jaddr_i} and leaves `link_o` low.
- R9: `taken_o` is high exactly when the next address is chosen by R4, R5, R6, R7 or R8 instead of the sequential advance.
- R10: Spliced targets take their upper bits from the current address. At pc 16'h003F, a taken 1011 with imm 5 goes to 16'h0005, not 16'h0045.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous reset, clears the address |
| op_i | input | 4 | Decoded opcode of the current instruction |
| imm_i | input | 6 | Immediate field, low bits of a branch target |
| jaddr_i | input | 12 | Jump field, low bits of a jump target |
| rs_val_i | input | 16 | First operand register value |
| rd_val_i | input | 16 | Second operand register value |
| pc_o | output | 16 | Current instruction address |
| pc_inc_o | output | 16 | Current address plus one (return address) |
| taken_o | output | 1 | Sequential advance is overridden this cycle |
| link_o | output | 1 | Link write requested (opcode 1110) |

## Verification
The hardest cases to reach from the ports are those where the address sits just below a splice boundary, such as 16'h003F or 16'h0FFF. There the incremented address has different upper bits from the current one, so a design that splices from the wrong source still looks correct at every other address. The only way to place the address at an arbitrary value is a register jump, so the bench first loads each chosen address with opcode 1101. It then applies every opcode with equal operands, unequal operands and zero operands. It compares the next address against a model computed in the bench.

// File: rtl/pc_steer_pkg.sv
package pc_steer_pkg;

    // Opcodes that redirect the address; all others advance sequentially.
    localparam logic [3:0] OPC_BR_EQ  = 4'b1011;
    localparam logic [3:0] OPC_BR_ZER = 4'b1100;
    localparam logic [3:0] OPC_JREG   = 4'b1101;
    localparam logic [3:0] OPC_JLINK  = 4'b1110;
    localparam logic [3:0] OPC_JABS   = 4'b1111;

    typedef enum logic [1:0] {
        SEL_SEQ   = 2'd0,   // current + 1
        SEL_SP_LO = 2'd1,   // splice immediate into low bits
        SEL_REG   = 2'd2,   // operand value
        SEL_SP_HI = 2'd3    // splice jump field under top bits
    } steer_sel_e;

endpackage

// File: rtl/pc_steer_incr.sv
module pc_steer_incr #(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_i,
    output logic [PC_W-1:0] pc_inc_o
);
    localparam logic [PC_W-1:0] ONE = {{(PC_W-1){1'b0}}, 1'b1};

    // Modulo add: carry out of the top bit is dropped, so all-ones wraps to zero.
    assign pc_inc_o = pc_i + ONE;

endmodule

// File: rtl/pc_steer_cond.sv
module pc_steer_cond
    import pc_steer_pkg::*;
#(
    parameter int PC_W = 16,
    parameter int OP_W = 4
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [PC_W-1:0] rs_i,
    input  logic [PC_W-1:0] rd_i,
    output steer_sel_e      sel_o,
    output logic            link_o
);
    logic ops_equal;
    logic rs_zero;

    assign ops_equal = (rs_i == rd_i);
    assign rs_zero   = (rs_i == '0);

    always_comb begin
        sel_o  = SEL_SEQ;
        link_o = 1'b0;
        case (op_i)
            OPC_BR_EQ:  sel_o = ops_equal ? SEL_SP_LO : SEL_SEQ;
            OPC_BR_ZER: sel_o = rs_zero   ? SEL_SP_LO : SEL_SEQ;
            OPC_JREG:   sel_o = SEL_REG;
            OPC_JLINK: begin
                sel_o  = SEL_SP_HI;
                link_o = 1'b1;
            end
            OPC_JABS:   sel_o = SEL_SP_HI;
            default:    sel_o = SEL_SEQ;
        endcase
    end

endmodule

// File: rtl/pc_steer_target.sv
module pc_steer_target
    import pc_steer_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 6,
    parameter int JMP_W = 12
) (
    input  steer_sel_e       sel_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic [PC_W-1:0]  pc_inc_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [JMP_W-1:0] jaddr_i,
    input  logic [PC_W-1:0]  rs_i,
    output logic [PC_W-1:0]  next_o
);
    localparam int LO_KEEP = PC_W - IMM_W;
    localparam int HI_KEEP = PC_W - JMP_W;

    logic [PC_W-1:0] br_tgt;
    logic [PC_W-1:0] jmp_tgt;

    // Upper bits come from the current address, not the incremented one.
    generate
        if (LO_KEEP > 0) begin : g_br_splice
            assign br_tgt = {pc_i[PC_W-1:IMM_W], imm_i};
        end else begin : g_br_full
            assign br_tgt = imm_i[PC_W-1:0];
        end
        if (HI_KEEP > 0) begin : g_jmp_splice
            assign jmp_tgt = {pc_i[PC_W-1:JMP_W], jaddr_i};
        end else begin : g_jmp_full
            assign jmp_tgt = jaddr_i[PC_W-1:0];
        end
    endgenerate

    always_comb begin
        case (sel_i)
            SEL_SP_LO: next_o = br_tgt;
            SEL_REG:   next_o = rs_i;
            SEL_SP_HI: next_o = jmp_tgt;
            default:   next_o = pc_inc_i;
        endcase
    end

endmodule

// File: rtl/pc_steer.sv
module pc_steer
    import pc_steer_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 6,
    parameter int JMP_W = 12,
    parameter int OP_W  = 4
) (
    input  logic             clk,
    input  logic             rst_i,
    input  logic [OP_W-1:0]  op_i,
    input  logic [IMM_W-1:0] imm_i,
    input  logic [JMP_W-1:0] jaddr_i,
    input  logic [PC_W-1:0]  rs_val_i,
    input  logic [PC_W-1:0]  rd_val_i,
    output logic [PC_W-1:0]  pc_o,
    output logic [PC_W-1:0]  pc_inc_o,
    output logic             taken_o,
    output logic             link_o
);
    typedef struct packed {
        logic [PC_W-1:0] pc;
    } steer_state_t;

    steer_state_t st_d, st_q;

    logic [PC_W-1:0] inc_w;
    logic [PC_W-1:0] target_w;
    steer_sel_e      sel_w;

    pc_steer_incr #(.PC_W(PC_W)) u_incr (
        .pc_i     (st_q.pc),
        .pc_inc_o (inc_w)
    );

    pc_steer_cond #(.PC_W(PC_W), .OP_W(OP_W)) u_cond (
        .op_i   (op_i),
        .rs_i   (rs_val_i),
        .rd_i   (rd_val_i),
        .sel_o  (sel_w),
        .link_o (link_o)
    );

    pc_steer_target #(.PC_W(PC_W), .IMM_W(IMM_W), .JMP_W(JMP_W)) u_target (
        .sel_i    (sel_w),
        .pc_i     (st_q.pc),
        .pc_inc_i (inc_w),
        .imm_i    (imm_i),
        .jaddr_i  (jaddr_i),
        .rs_i     (rs_val_i),
        .next_o   (target_w)
    );

    always_comb begin
        st_d = st_q;
        if (rst_i) begin
            st_d.pc = '0;
        end else begin
            st_d.pc = target_w;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign pc_o     = st_q.pc;
    assign pc_inc_o = inc_w;
    assign taken_o  = (sel_w != SEL_SEQ);

endmodule

// File: rtl/pc_steer_chk.sv
module pc_steer_chk
    import pc_steer_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int IMM_W = 6,
    parameter int JMP_W = 12,
    parameter int OP_W  = 4
) (
    input logic             clk,
    input logic             rst_i,
    input logic [OP_W-1:0]  op_i,
    input logic [IMM_W-1:0] imm_i,
    input logic [JMP_W-1:0] jaddr_i,
    input logic [PC_W-1:0]  rs_val_i,
    input logic [PC_W-1:0]  rd_val_i,
    input logic [PC_W-1:0]  pc_o,
    input logic [PC_W-1:0]  pc_inc_o,
    input logic             taken_o,
    input logic             link_o
);
    logic rst_prev_q;

    always_ff @(posedge clk) begin
        rst_prev_q <= rst_i;
    end

    // R1: the edge after a sampled reset leaves the address at zero.
    always @(posedge clk) begin
        if (rst_prev_q === 1'b1) begin
            assert_reset_clear_R1: assert (pc_o == '0);
        end
    end

    // R2 / R3: without a redirect the address becomes the previous return address.
    assert_seq_advance_R2: assert property (@(posedge clk) disable iff (rst_i)
        !taken_o |=> (pc_o == $past(pc_inc_o)));

    assert_beq_taken_R4: assert property (@(posedge clk) disable iff (rst_i)
        (op_i == OPC_BR_EQ && rs_val_i == rd_val_i) |-> taken_o);

    assert_beqz_hold_R5: assert property (@(posedge clk) disable iff (rst_i)
        (op_i == OPC_BR_ZER && rs_val_i != '0) |-> !taken_o);

    assert_jreg_load_R6: assert property (@(posedge clk) disable iff (rst_i)
        (op_i == OPC_JREG) |=> (pc_o == $past(rs_val_i)));

    assert_link_only_R7: assert property (@(posedge clk) disable iff (rst_i)
        link_o |-> (op_i == OPC_JLINK));

    assert_jump_low_R8: assert property (@(posedge clk) disable iff (rst_i)
        (op_i == OPC_JABS || op_i == OPC_JLINK) |=>
            (pc_o[JMP_W-1:0] == $past(jaddr_i)));

    assert_branch_upper_R10: assert property (@(posedge clk) disable iff (rst_i)
        (taken_o && (op_i == OPC_BR_EQ || op_i == OPC_BR_ZER)) |=>
            (pc_o[PC_W-1:IMM_W] == $past(pc_o[PC_W-1:IMM_W])));

    assert_jump_upper_R10: assert property (@(posedge clk) disable iff (rst_i)
        (op_i == OPC_JABS || op_i == OPC_JLINK) |=>
            (pc_o[PC_W-1:JMP_W] == $past(pc_o[PC_W-1:JMP_W])));

endmodule

bind pc_steer pc_steer_chk #(
    .PC_W(PC_W), .IMM_W(IMM_W), .JMP_W(JMP_W), .OP_W(OP_W)
) u_chk (
    .clk      (clk),
    .rst_i    (rst_i),
    .op_i     (op_i),
    .imm_i    (imm_i),
    .jaddr_i  (jaddr_i),
    .rs_val_i (rs_val_i),
    .rd_val_i (rd_val_i),
    .pc_o     (pc_o),
    .pc_inc_o (pc_inc_o),
    .taken_o  (taken_o),
    .link_o   (link_o)
);

// File: tb/sim_pc_steer.sv
`timescale 1ns/1ps
module sim_pc_steer;

    logic        clk = 1'b0;
    logic        rst_i;
    logic [3:0]  op_i;
    logic [5:0]  imm_i;
    logic [11:0] jaddr_i;
    logic [15:0] rs_val_i;
    logic [15:0] rd_val_i;
    logic [15:0] pc_o;
    logic [15:0] pc_inc_o;
    logic        taken_o;
    logic        link_o;

    int n_checks = 0;
    int n_fail   = 0;
    logic [15:0] model_pc;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 4 ns period

    pc_steer u0 (
        .clk(clk), .rst_i(rst_i), .op_i(op_i), .imm_i(imm_i),
        .jaddr_i(jaddr_i), .rs_val_i(rs_val_i), .rd_val_i(rd_val_i),
        .pc_o(pc_o), .pc_inc_o(pc_inc_o), .taken_o(taken_o), .link_o(link_o)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic ref_taken(input logic [3:0] op,
                                       input logic [15:0] rs, input logic [15:0] rd);
        case (op)
            4'd11:   return rs == rd;
            4'd12:   return rs == 16'd0;
            4'd13, 4'd14, 4'd15: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [15:0] ref_next(input logic [15:0] pc, input logic [3:0] op,
                                             input logic [5:0] imm, input logic [11:0] ja,
                                             input logic [15:0] rs, input logic [15:0] rd);
        logic [15:0] seq;
        seq = pc + 16'd1;
        case (op)
            4'd11:   return (rs == rd)    ? {pc[15:6], imm} : seq;
            4'd12:   return (rs == 16'd0) ? {pc[15:6], imm} : seq;
            4'd13:   return rs;
            4'd14, 4'd15: return {pc[15:12], ja};
            default: return seq;
        endcase
    endfunction

    function automatic string next_tag(input logic [3:0] op);
        case (op)
            4'd11:   return "R4 next pc";
            4'd12:   return "R5 next pc";
            4'd13:   return "R6 next pc";
            4'd14:   return "R7 next pc";
            4'd15:   return "R8 next pc";
            default: return "R2 next pc";
        endcase
    endfunction

    task automatic step(input logic [3:0] op, input logic [5:0] imm, input logic [11:0] ja,
                        input logic [15:0] rs, input logic [15:0] rd, input bit rst);
        logic [15:0] exp;
        @(negedge clk);
        op_i = op; imm_i = imm; jaddr_i = ja; rs_val_i = rs; rd_val_i = rd; rst_i = rst;
        #1;
        check(pc_inc_o == model_pc + 16'd1, "R3 pc_inc", pc_inc_o, model_pc + 16'd1);
        check(taken_o == ref_taken(op, rs, rd), "R9 taken", {15'd0, taken_o},
              {15'd0, ref_taken(op, rs, rd)});
        check(link_o == (op == 4'd14), "R7 link", {15'd0, link_o}, {15'd0, op == 4'd14});
        exp = rst ? 16'd0 : ref_next(model_pc, op, imm, ja, rs, rd);
        @(posedge clk);
        #1;
        check(pc_o == exp, rst ? "R1 reset" : next_tag(op), pc_o, exp);
        model_pc = exp;
        rst_i = 1'b0;
    endtask

    task automatic load_pc(input logic [15:0] v);
        step(4'd13, 6'd0, 12'd0, v, 16'h5555, 1'b0);
    endtask

    initial begin
        logic [15:0] pcs [6];
        pcs = '{16'h0000, 16'h003F, 16'h0FFF, 16'hFFFF, 16'h1234, 16'hABC0};
        rst_i = 1'b1; op_i = 4'd13; imm_i = 6'h3F; jaddr_i = 12'hFFF;
        rs_val_i = 16'hBEEF; rd_val_i = 16'h0000;
        repeat (2) @(posedge clk);
        #1;
        check(pc_o == 16'd0, "R1 reset state", pc_o, 16'd0);
        model_pc = 16'd0;

        // Sweep: every opcode, several start addresses, three operand patterns.
        for (int p = 0; p < 6; p++) begin
            for (int o = 0; o < 16; o++) begin
                for (int k = 0; k < 3; k++) begin
                    logic [15:0] a, b;
                    a = (k == 0) ? 16'h7A31 : ((k == 1) ? 16'h7A31 : 16'h0000);
                    b = (k == 0) ? 16'h7A31 : ((k == 1) ? 16'h7A30 : 16'h0000);
                    load_pc(pcs[p]);
                    step(4'(o), 6'h2A ^ 6'(k), 12'h5C3 ^ 12'(o), a, b, 1'b0);
                end
            end
        end

        // R2: wrap at the top of the address space.
        load_pc(16'hFFFF);
        step(4'd0, 6'd0, 12'd0, 16'd1, 16'd2, 1'b0);
        check(pc_o == 16'h0000, "R2 wrap", pc_o, 16'h0000);

        // R10: splice uses the current upper bits at a boundary.
        load_pc(16'h003F);
        step(4'd11, 6'd5, 12'd0, 16'h0101, 16'h0101, 1'b0);
        check(pc_o == 16'h0005, "R10 branch splice", pc_o, 16'h0005);
        load_pc(16'h0FFF);
        step(4'd14, 6'd0, 12'h123, 16'd0, 16'd0, 1'b0);
        check(pc_o == 16'h0123, "R10 jump splice", pc_o, 16'h0123);

        // R1: reset overrides a jump in the same cycle.
        load_pc(16'h1234);
        step(4'd15, 6'd0, 12'hABC, 16'd0, 16'd0, 1'b1);
        check(pc_o == 16'h0000, "R1 reset beats jump", pc_o, 16'h0000);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 16'd0, 16'd1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule